// File: doc/BRIEF.md
# Spin-Then-Swap Lock Requester with Randomised Backoff

This block acquires a single shared lock bit on behalf of one local client. The lock bit lives in a shared register reached through a simple request/acknowledge port that offers three operations: a plain read, an atomic swap that writes 1 and returns the previous value, and a clear that writes 0. A lock value of 0 means free and 1 means taken.

When the client raises its acquire request, the requester polls with plain reads for as long as the lock reads taken. It attempts the atomic swap only after a read returns free. A swap that returns 0 wins the lock, and the requester raises `granted` until the client pulses release. The requester then clears the lock with a plain write of 0. A swap that returns 1 loses. The requester then idles for a pseudo-random number of cycles taken modulo a backoff window, and returns to polling. The window starts at a minimum on every new acquire and doubles after each lost swap until it reaches a cap. The client may withdraw its request while the requester is polling or backing off. The requester then returns to idle at once, with nothing to undo.

Top module: `ttas_lock_requester`

## Requirements
- R1: After reset the requester is idle: `memReq` is 0 and `granted` is 0.
- R2: While the most recent read returned 1 and the request is held, the requester issues only reads (`memOp` 0). A swap never directly follows a read that returned 1.
- R3: A read returning 0 is followed, in the next cycle, by a swap request (`memOp` 1). A swap completing with read data 0 makes `granted` 1 from the next cycle on.
- R4: A swap completing with data 1 is followed by delay+1 cycles with `memReq` low, then reads resume. The delay is the LFSR value modulo the current window.
- R5: The window is a power of two. It is set to MIN_WIN when an acquire starts from idle, and after each lost swap it doubles if it is below MAX_WIN. Otherwise it stays the same.
- R6: A release pulse while `granted` is 1 drops `granted` in the next cycle and issues a clear (`memOp` 2). The clear is held until acknowledged, after which the requester is idle.
- R7: A release pulse while `granted` is 0 has no effect: no clear is issued and the state is unchanged.
- R8: Dropping `acqReq` while polling or backing off returns the requester to idle in the next cycle. Once a swap has been issued, it completes regardless.
- R9: The random source is a 16-bit Fibonacci LFSR with taps 16,14,13,11. It shifts left each cycle with the new bit entering at bit 0, and is loaded with SEED at reset. The delay uses its low bits as they stand at the edge where the swap completes.
- R10: An operation completes only at an edge where both `memReq` and `memAck` are 1. Swap and clear requests hold `memOp` stable until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| acqReq | input | 1 | Client acquire request, level |
| relPulse | input | 1 | Client release pulse |
| granted | output | 1 | Lock is held for the client |
| memReq | output | 1 | Lock-port operation request |
| memOp | output | 2 | Operation: 0 read, 1 swap-in-1, 2 clear |
| memAck | input | 1 | Lock port accepts the operation this cycle |
| memRdata | input | 1 | Lock value (prior value on swap) valid with ack |

## Verification
A wrong state register or strobe shows at the ports within one cycle. The cases are a swap request where a read is due, `memReq` staying high through a backoff, or `granted` changing an edge early or late. A wrong window or LFSR value does not show until the next lost swap, and then only as a backoff that is too long or too short. For that reason the bench forces chains of lost swaps, which walk the window up to its cap. It compares the length of every quiet stretch cycle by cycle against a behavioural model.

// File: rtl/ttas_lock_pkg.sv
package ttas_lock_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_SWAP  = 2'd1,
    OP_CLEAR = 2'd2
  } lockOp_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_SWAP,
    ST_BACKOFF,
    ST_HELD,
    ST_RELEASE
  } reqState_e;

  typedef struct packed {
    logic winReset;
    logic winGrow;
    logic delayLoad;
    logic delayDec;
  } dpStrobe_t;
endpackage

// File: rtl/lockreq_dp.sv
module lockreq_dp
  import ttas_lock_pkg::*;
#(
  parameter logic [15:0] SEED    = 16'hACE1,
  parameter int          MIN_WIN = 4,
  parameter int          MAX_WIN = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  output logic       delayZero
);
  localparam int CNT_W = $clog2(MAX_WIN);
  localparam int WIN_W = CNT_W + 1;

  logic [15:0]      lfsr;
  logic             lfsrFb;
  logic [WIN_W-1:0] window;
  logic [WIN_W-1:0] winMask;
  logic [CNT_W-1:0] delayCnt;
  logic [CNT_W-1:0] randDelay;

  assign lfsrFb    = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];
  assign winMask   = window - 1'b1;
  assign randDelay = lfsr[CNT_W-1:0] & winMask[CNT_W-1:0];
  assign delayZero = (delayCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsr <= SEED;
    else       lfsr <= {lfsr[14:0], lfsrFb};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      window <= WIN_W'(MIN_WIN);
    else if (strobe.winReset)
      window <= WIN_W'(MIN_WIN);
    else if (strobe.winGrow && (window < WIN_W'(MAX_WIN)))
      window <= window << 1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 delayCnt <= '0;
    else if (strobe.delayLoad) delayCnt <= randDelay;
    else if (strobe.delayDec)  delayCnt <= delayCnt - 1'b1;
  end

  // R5: window stays a power of two inside its bounds
  p_window_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(window) && (window != '0) &&
    (window >= WIN_W'(MIN_WIN)) && (window <= WIN_W'(MAX_WIN)));

  // R4: a loaded delay is below the window in force at the lost swap
  p_delay_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.delayLoad |=> ({1'b0, delayCnt} < $past(window)));

  // R9: the LFSR never reaches the all-zero lockup state
  p_lfsr_live_r9: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != 16'd0);
endmodule

// File: rtl/lockreq_ctrl.sv
module lockreq_ctrl
  import ttas_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       acqReq,
  input  logic       relPulse,
  input  logic       memAck,
  input  logic       memRdata,
  input  logic       delayZero,
  output dpStrobe_t  strobe,
  output logic       memReq,
  output lockOp_e    memOp,
  output logic       granted
);
  reqState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (acqReq) begin
        nextState       = ST_POLL;
        strobe.winReset = 1'b1;
      end
      ST_POLL: begin
        if (!acqReq)                   nextState = ST_IDLE;
        else if (memAck && !memRdata)  nextState = ST_SWAP;
      end
      ST_SWAP: if (memAck) begin
        if (!memRdata) nextState = ST_HELD;
        else begin
          nextState        = ST_BACKOFF;
          strobe.delayLoad = 1'b1;
          strobe.winGrow   = 1'b1;
        end
      end
      ST_BACKOFF: begin
        if (!acqReq)        nextState = ST_IDLE;
        else if (delayZero) nextState = ST_POLL;
        else                strobe.delayDec = 1'b1;
      end
      ST_HELD:    if (relPulse) nextState = ST_RELEASE;
      ST_RELEASE: if (memAck)   nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  assign memReq  = (state == ST_POLL) || (state == ST_SWAP) || (state == ST_RELEASE);
  assign granted = (state == ST_HELD);
  always_comb begin
    unique case (state)
      ST_SWAP:    memOp = OP_SWAP;
      ST_RELEASE: memOp = OP_CLEAR;
      default:    memOp = OP_READ;
    endcase
  end

  // R2: a read that saw the lock taken is never followed by a swap
  p_no_swap_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && memOp == OP_READ && memRdata) |=> !(memReq && memOp == OP_SWAP));

  // R3: grant rises only after a winning swap
  p_grant_after_win_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(granted) |-> $past(memReq && memAck && memOp == OP_SWAP && !memRdata));

  // R6: release while granted drops grant and issues the clear
  p_release_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (relPulse && granted) |=> (!granted && memReq && memOp == OP_CLEAR));

  // R7: release without grant never produces a clear
  p_release_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (relPulse && !granted && !memReq) |=> !(memReq && memOp == OP_CLEAR));

  // R8: withdrawing the request while polling or backing off ends in idle
  p_abandon_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_POLL || state == ST_BACKOFF) && !acqReq) |=> (state == ST_IDLE));

  // R10: swap and clear requests hold until acknowledged
  p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && memOp != OP_READ) |=> (memReq && $stable(memOp)));
endmodule

// File: rtl/ttas_lock_requester.sv
module ttas_lock_requester
  import ttas_lock_pkg::*;
#(
  parameter logic [15:0] SEED    = 16'hACE1,
  parameter int          MIN_WIN = 4,
  parameter int          MAX_WIN = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       acqReq,
  input  logic       relPulse,
  output logic       granted,
  output logic       memReq,
  output logic [1:0] memOp,
  input  logic       memAck,
  input  logic       memRdata
);
  dpStrobe_t strobe;
  logic      delayZero;
  lockOp_e   opSel;

  lockreq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .acqReq    (acqReq),
    .relPulse  (relPulse),
    .memAck    (memAck),
    .memRdata  (memRdata),
    .delayZero (delayZero),
    .strobe    (strobe),
    .memReq    (memReq),
    .memOp     (opSel),
    .granted   (granted)
  );

  lockreq_dp #(
    .SEED    (SEED),
    .MIN_WIN (MIN_WIN),
    .MAX_WIN (MAX_WIN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .delayZero (delayZero)
  );

  assign memOp = opSel;
endmodule

// File: tb/ttas_lock_requester_tb.sv
`timescale 1ns/1ps
module ttas_lock_requester_tb;
  localparam logic [15:0] SEED = 16'hB3C5;
  localparam int MIN_W = 4;
  localparam int MAX_W = 64;
  localparam int S_IDLE = 0, S_POLL = 1, S_SWAP = 2, S_BACK = 3, S_HELD = 4, S_REL = 5;

  logic clk = 0;
  logic rstN = 0;
  logic acqReq = 0, relPulse = 0, memAck = 1;
  logic granted, memReq, memRdata;
  logic [1:0] memOp;

  logic lockBit = 0;
  logic otherSet = 0, otherClr = 0, autoFree = 0, stallMode = 0;
  int racerArm = 0, racerUsed = 0, lostCnt = 0;
  int cyc = 0;
  int compared = 0, mismatched = 0;

  int mS = S_IDLE, mW = MIN_W, mC = 0;
  logic [15:0] mL = SEED;

  assign memRdata = lockBit;

  always #4 clk = ~clk;

  ttas_lock_requester #(.SEED(SEED), .MIN_WIN(MIN_W), .MAX_WIN(MAX_W)) u_dut (
    .clk(clk), .rstN(rstN), .acqReq(acqReq), .relPulse(relPulse),
    .granted(granted), .memReq(memReq), .memOp(memOp),
    .memAck(memAck), .memRdata(memRdata));

  function automatic string tagOf(int s);
    case (s)
      S_IDLE:  return "R1/R7/R8";
      S_POLL:  return "R2";
      S_SWAP:  return "R3";
      S_BACK:  return "R4/R5/R9";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // Reference model and shared lock register, advanced on every edge
  always @(posedge clk) begin
    logic nxt, mReq, fb;
    int mOp, oldS;
    cyc++;
    if (!rstN) begin
      mS = S_IDLE; mW = MIN_W; mC = 0; mL = SEED;
    end else begin
      mReq = (mS == S_POLL) || (mS == S_SWAP) || (mS == S_REL);
      mOp  = (mS == S_SWAP) ? 1 : (mS == S_REL) ? 2 : 0;
      nxt = lockBit;
      if (otherSet) nxt = 1'b1;
      if (otherClr) nxt = 1'b0;
      if (mReq && memAck && mOp == 1) nxt = 1'b1;
      if (mReq && memAck && mOp == 2) nxt = 1'b0;
      oldS = mS;
      fb = mL[15] ^ mL[13] ^ mL[12] ^ mL[10];
      case (mS)
        S_IDLE: if (acqReq) begin mW = MIN_W; mS = S_POLL; end
        S_POLL: if (!acqReq) mS = S_IDLE;
                else if (memAck && !lockBit) mS = S_SWAP;
        S_SWAP: if (memAck) begin
          if (!lockBit) mS = S_HELD;
          else begin
            mC = int'(mL) % mW;
            if (mW < MAX_W) mW = mW * 2;
            mS = S_BACK;
            lostCnt++;
            if (autoFree) nxt = 1'b0;
          end
        end
        S_BACK: if (!acqReq) mS = S_IDLE;
                else if (mC == 0) mS = S_POLL;
                else mC--;
        S_HELD: if (relPulse) mS = S_REL;
        default: if (memAck) mS = S_IDLE;
      endcase
      if (oldS == S_POLL && mS == S_SWAP && racerUsed < racerArm) begin
        nxt = 1'b1;
        racerUsed++;
      end
      mL = {mL[14:0], fb};
      lockBit <= nxt;
    end
  end

  always @(negedge clk) memAck <= stallMode ? (cyc % 3 != 0) : 1'b1;

  // Per-cycle comparison of outputs against the model
  always @(negedge clk) begin
    logic eReq, eGr;
    int eOp;
    if (rstN) begin
      eReq = (mS == S_POLL) || (mS == S_SWAP) || (mS == S_REL);
      eOp  = (mS == S_SWAP) ? 1 : (mS == S_REL) ? 2 : 0;
      eGr  = (mS == S_HELD);
      chk(memReq == eReq, tagOf(mS), memReq, eReq);
      chk(granted == eGr, tagOf(mS), granted, eGr);
      if (eReq) chk(memOp == 2'(eOp), "R10", memOp, eOp);
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    mismatched++;
    $display("FAIL watchdog: actual=hung expected=done");
    finishRun();
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitGrant(string tag);
    bit got = 0;
    for (int i = 0; i < 3000; i++) begin
      tick();
      if (granted) begin got = 1; break; end
    end
    chk(got, tag, got, 1);
  endtask

  task automatic doRelease();
    acqReq = 0; relPulse = 1; tick(); relPulse = 0;
    tick(6);
    chk(lockBit == 1'b0, "R6", lockBit, 0);
    chk(!granted && !memReq, "R6", granted, 0);
  endtask

  task automatic pulseOther(bit setIt);
    if (setIt) otherSet = 1; else otherClr = 1;
    tick(); otherSet = 0; otherClr = 0;
  endtask

  initial begin
    int quiet;
    bit sawSwap;
    tick(3);
    chk(!memReq && !granted, "R1", {memReq, granted}, 0);
    rstN = 1; tick(2);
    chk(!memReq && !granted, "R1", {memReq, granted}, 0);

    // free lock: read, swap, win
    acqReq = 1;
    waitGrant("R3");
    doRelease();

    // release with no grant: nothing happens
    relPulse = 1; tick(); relPulse = 0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(!memReq && !granted && lockBit == 1'b0, "R7", memReq, 0);
    end

    // lock held by another agent: only reads
    pulseOther(1);
    acqReq = 1;
    sawSwap = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (memReq && memOp == 2'd1) sawSwap = 1;
    end
    chk(!sawSwap, "R2", sawSwap, 0);
    // abandon while polling
    acqReq = 0; tick();
    chk(!memReq, "R8", memReq, 0);
    tick(3);
    chk(!memReq && lockBit == 1'b1, "R8", memReq, 0);
    pulseOther(0);

    // lost swap, abandon during backoff
    autoFree = 0; racerArm = racerUsed + 1;
    acqReq = 1;
    for (int i = 0; i < 50; i++) begin
      tick();
      if (!memReq && acqReq && lostCnt > 0) break;
    end
    acqReq = 0; tick();
    chk(!memReq && !granted, "R8", memReq, 0);
    tick(4);
    chk(!memReq, "R8", memReq, 0);
    pulseOther(0);

    // fresh acquire: window back at minimum, one lost swap
    autoFree = 1; racerArm = racerUsed + 1;
    acqReq = 1;
    for (int i = 0; i < 50; i++) begin
      tick();
      if (!memReq) break;
    end
    quiet = 0;
    while (!memReq && quiet < 200) begin quiet++; tick(); end
    chk(quiet >= 1 && quiet <= MIN_W, "R5", quiet, MIN_W);
    waitGrant("R3");
    doRelease();

    // long contention chain with stalled acks: window climbs to its cap
    stallMode = 1; lostCnt = 0;
    racerArm = racerUsed + 7;
    acqReq = 1;
    waitGrant("R4");
    chk(lostCnt == 7, "R4", lostCnt, 7);
    stallMode = 0;
    doRelease();

    // second chain without stalls
    lostCnt = 0; racerArm = racerUsed + 3;
    acqReq = 1;
    waitGrant("R9");
    chk(lostCnt == 3, "R5", lostCnt, 3);
    doRelease();

    autoFree = 0;
    tick(4);
    finishRun();
  end
endmodule